// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a configurable two-level logic array of the sort found inside small programmable logic devices. A vector of input signals feeds a set of product terms. Each product term is the AND of any chosen mix of true and complemented inputs. Each output is the OR of a chosen subset of those product terms. Every product term is also brought out on its own pin, so that it can drive a clock, set, reset or clock-enable input directly without passing through an OR stage.

The configuration is a single internal bit array that is loaded serially, one bit per clock, while a load strobe is high. The bit that leaves the array on each shift is presented on a readback pin, so a controller can verify the configuration as it replaces it. Once loaded, the array is purely combinational from the inputs to the outputs. While the load strobe is high, all outputs are held low so that a half-written configuration never reaches downstream logic.

Top module: `prog_sop_array`

## Requirements
- R1: Literal coding. For product term t and input i, configuration bit 2*(t*NUM_IN+i) enables the complemented literal and bit 2*(t*NUM_IN+i)+1 enables the true literal. The term is the AND of all enabled literals.
- R2: A product term with no literal bits set evaluates to 1.
- R3: If both literal bits of one input are set for a term, that term evaluates to 0 for every input value.
- R4: Output o is the OR of every term t whose mask bit LIT_BITS + o*NUM_TERMS + t is set, where LIT_BITS = 2*NUM_IN*NUM_TERMS.
- R5: An output whose mask is empty evaluates to 0.
- R6: Each product term t appears unchanged on term_out[t].
- R7: While cfg_load is high, each rising clock shifts the configuration down by one position. cfg_din enters the top index (CFG_BITS-1). A full load therefore sends the first bit shifted in to index 0.
- R8: cfg_dout always shows configuration bit 0, so a load reads out the old configuration starting from index 0. While cfg_load is low, the configuration (and therefore cfg_dout) does not change.
- R9: While cfg_load is high, term_out and sum_out are all 0.
- R10: An active-low asynchronous reset clears the configuration. Afterwards all terms read 1, all outputs read 0, and cfg_dout reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration shifting |
| rst_n | input | 1 | Asynchronous active-low reset; clears the configuration |
| cfg_load | input | 1 | Shift enable; also forces the outputs low |
| cfg_din | input | 1 | Serial configuration bit, entering at the top index |
| cfg_dout | output | 1 | Readback of configuration bit 0 |
| in_vec | input | NUM_IN | Logic inputs to the array |
| term_out | output | NUM_TERMS | Individual product terms |
| sum_out | output | NUM_OUT | OR-term outputs |

## Verification
The checker watches four properties on every cycle:
- the outputs are forced low during a load;
- the readback bit is stable whenever no load is in progress;
- an output can only be high when some product term is high;
- the configuration is cleared on the cycle after reset.

The following can only be shown by the bench's scenarios, which compare the array against hand-built configurations:
- the exact bit positions of the literal codes and the OR masks;
- empty-term and empty-mask behaviour;
- a conflicting literal pair forcing its term to zero;
- the order in which old configuration bits appear during readback.

// File: rtl/prog_sop_array.sv
module prog_sop_array #(
  parameter int NUM_IN    = 40,
  parameter int NUM_TERMS = 56,
  parameter int NUM_OUT   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic                 cfg_din,
  output logic                 cfg_dout,
  input  logic [NUM_IN-1:0]    in_vec,
  output logic [NUM_TERMS-1:0] term_out,
  output logic [NUM_OUT-1:0]   sum_out
);
  localparam int LIT_BITS  = 2 * NUM_IN * NUM_TERMS;
  localparam int MASK_BITS = NUM_OUT * NUM_TERMS;
  localparam int CFG_BITS  = LIT_BITS + MASK_BITS;

  logic [CFG_BITS-1:0]  cfg_q;
  logic [NUM_TERMS-1:0] term_raw;
  logic [NUM_OUT-1:0]   sum_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_q <= '0;
    else if (cfg_load)
      cfg_q <= {cfg_din, cfg_q[CFG_BITS-1:1]};
  end

  assign cfg_dout = cfg_q[0];

  always_comb begin
    for (int t = 0; t < NUM_TERMS; t++) begin
      logic acc;
      acc = 1'b1;
      for (int i = 0; i < NUM_IN; i++) begin
        acc = acc
            & (~cfg_q[2*(t*NUM_IN+i)]   | ~in_vec[i])
            & (~cfg_q[2*(t*NUM_IN+i)+1] |  in_vec[i]);
      end
      term_raw[t] = acc;
    end
  end

  always_comb begin
    for (int o = 0; o < NUM_OUT; o++)
      sum_raw[o] = |(term_raw & cfg_q[LIT_BITS + o*NUM_TERMS +: NUM_TERMS]);
  end

  assign term_out = cfg_load ? '0 : term_raw;
  assign sum_out  = cfg_load ? '0 : sum_raw;
endmodule

// File: rtl/prog_sop_array_chk.sv
module prog_sop_array_chk #(
  parameter int NUM_IN    = 40,
  parameter int NUM_TERMS = 56,
  parameter int NUM_OUT   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_load,
  input logic                 cfg_dout,
  input logic [NUM_IN-1:0]    in_vec,
  input logic [NUM_TERMS-1:0] term_out,
  input logic [NUM_OUT-1:0]   sum_out
);
  assert_gated_in_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> (term_out == '0 && sum_out == '0));

  assert_cfg_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && !$past(cfg_load)) |-> $stable(cfg_dout));

  assert_sum_needs_term_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_out != '0) |-> (term_out != '0));

  assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n) && !cfg_load) |-> (&term_out && sum_out == '0 && !cfg_dout));
endmodule

bind prog_sop_array prog_sop_array_chk #(
  .NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS), .NUM_OUT(NUM_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_dout(cfg_dout),
  .in_vec(in_vec), .term_out(term_out), .sum_out(sum_out)
);

// File: tb/sim_prog_sop_array.sv
`timescale 1ns/1ps
module sim_prog_sop_array;
  localparam int NI = 4, NT = 4, NO = 2;
  localparam int LIT = 2*NI*NT;
  localparam int TOT = LIT + NO*NT;

  logic clk = 0, rst_n = 0, cfg_load = 0, cfg_din = 0;
  logic cfg_dout;
  logic [NI-1:0] in_vec = '0;
  logic [NT-1:0] term_out;
  logic [NO-1:0] sum_out;
  int checks = 0, errors = 0;
  logic [TOT-1:0] cfg_a, cfg_b, rb;

  always #2 clk = ~clk;

  prog_sop_array #(.NUM_IN(NI), .NUM_TERMS(NT), .NUM_OUT(NO)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .in_vec(in_vec), .term_out(term_out), .sum_out(sum_out));

  // {in, term, sum} under config A: t0=x0&~x1, t1=x2&x3, t2=empty, t3=conflict; s0=t0|t1, s1=t3
  localparam logic [9:0] VEC [8] = '{
    {4'b0000, 4'b0100, 2'b00}, {4'b0001, 4'b0101, 2'b01},
    {4'b0011, 4'b0100, 2'b00}, {4'b1100, 4'b0110, 2'b01},
    {4'b1101, 4'b0111, 2'b01}, {4'b1110, 4'b0110, 2'b01},
    {4'b0100, 4'b0100, 2'b00}, {4'b1000, 4'b0100, 2'b00}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [TOT-1:0] cfg, output logic [TOT-1:0] old);
    for (int k = 0; k < TOT; k++) begin
      @(negedge clk);
      old[k] = cfg_dout;
      if (k == 1) chk("R9 outputs low in load", {term_out, sum_out}, 0);
      cfg_load = 1; cfg_din = cfg[k];
    end
    @(negedge clk);
    cfg_load = 0;
    #1;
  endtask

  initial begin
    cfg_a = '0;
    cfg_a[1] = 1; cfg_a[2] = 1; cfg_a[13] = 1; cfg_a[15] = 1;
    cfg_a[24] = 1; cfg_a[25] = 1;
    cfg_a[LIT+0] = 1; cfg_a[LIT+1] = 1; cfg_a[LIT+NT+3] = 1;
    cfg_b = '0;
    cfg_b[LIT+NT+2] = 1;
    cfg_b[2*(1*NI+3)] = 1;

    #5;
    chk("R10 reset terms", term_out, 4'hF);
    chk("R10 reset sums", sum_out, 0);
    chk("R10 reset dout", cfg_dout, 0);
    @(negedge clk); rst_n = 1;

    load(cfg_a, rb);
    chk("R8 readback after reset", rb, 0);
    for (int v = 0; v < 8; v++) begin
      in_vec = VEC[v][9:6];
      #1;
      chk("R1 R2 R3 R6 terms", term_out, VEC[v][5:2]);
      chk("R4 sums", sum_out, VEC[v][1:0]);
    end

    repeat (5) @(negedge clk);
    chk("R8 held dout", cfg_dout, cfg_a[0]);

    load(cfg_b, rb);
    chk("R7 R8 readback order", rb, cfg_a);
    in_vec = 4'b1000; #1;
    chk("R5 empty mask / R1 comp", {term_out, sum_out}, {4'b1101, 2'b10});
    in_vec = 4'b0000; #1;
    chk("R1 comp literal", term_out, 4'b1111);

    @(negedge clk); rst_n = 0; #1;
    chk("R10 async reset", {term_out, sum_out, cfg_dout}, {4'hF, 2'b00, 1'b0});
    @(negedge clk); rst_n = 1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule